// File: doc/BRIEF.md
# Page-Bounded Flash Program Sequencer

This block turns one host write request into the serial flash command traffic that stores it. The request gives a start address and a byte count. The block checks that the write fits inside the device, then cuts it into chunks. No chunk may reach past the end of a flash page. For each chunk it polls the device status until the device is idle, sends a one-byte write-enable command, and then sends a page-program command. That command is the opcode, three address bytes and the chunk's data, which the block pulls from a valid/ready byte stream.

All serial traffic goes through a byte-exchange port. The block presents a byte and a flag that marks the last byte of a command, which ends the chip-select frame. The shifter returns an acknowledge and the byte it received. When the job ends, the block pulses `done`, raises `err` if the job was refused or the device never became idle, and holds the number of data bytes that went to the device. Header bytes are not included in that count.

Top module: `flash_prog_splitter`

## Requirements
- R1: A start with a length of zero gives `done` in the next cycle, with `err` low, `written` zero and no byte exchanged.
- R2: A start whose address plus length exceeds DEV_BYTES gives `done` in the next cycle, with `err` high, `written` zero and no byte exchanged. An end that lands exactly on DEV_BYTES is accepted.
- R3: Each program command covers addresses inside one PAGE_BYTES page. The first chunk is the smaller of the length and PAGE_BYTES minus the page offset. Each later chunk is the smaller of PAGE_BYTES and the bytes left, and starts at the start address plus the bytes already sent.
- R4: A program command is opcode 0x02, then the 24-bit address high byte first, then the data. The last-byte flag is set only on the chunk's final data byte.
- R5: Before each chunk the block sends status polls. A poll is 0x05 followed by one filler byte 0x00 that carries the last flag. Bit 0 of the byte received with the filler means busy. Polls repeat while that bit is 1. Once it is 0, the block sends 0x06 as a single-byte command.
- R6: `written` counts data bytes only. It is cleared when a job is accepted, rises by one per acknowledged data byte, and equals the length when a job completes without error. `done` is a one-cycle pulse.
- R7: `in_ready` is high only while the block waits for the next data byte, never while a byte exchange is requested. Stream bytes are sent in arrival order.
- R8: If POLL_LIMIT polls in a row before one chunk all read busy, the job aborts with `done` and `err` high. `written` keeps the bytes already programmed, and no further command follows.
- R9: After reset, `busy`, `done`, `err`, `xfer_req`, `in_ready` and `written` are all zero.
- R10: A start pulse while a job is running is ignored, and the running job's traffic and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a job (taken only when idle) |
| start_addr | input | ADDR_W | First byte address of the write |
| start_len | input | LEN_W | Number of bytes to write |
| in_data | input | 8 | Host data byte |
| in_valid | input | 1 | Host data byte valid |
| in_ready | output | 1 | Block accepts a host data byte |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_last | output | 1 | Byte ends the current command frame |
| xfer_ack | input | 1 | Exchange of the presented byte is finished |
| xfer_rx | input | 8 | Byte received during the acknowledged exchange |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Last job refused or timed out |
| written | output | LEN_W | Data bytes programmed by the last job |

## Verification
The bench builds the block with a 16-byte page, a 1024-byte device, 12-bit address and length, and a limit of four polls. The small page means that a 40-byte write already produces a trimmed head chunk, two full pages and a short tail. It also means that writes which end exactly on a page edge, or one byte past it, can be reached with small lengths. A four-poll limit lets the bench put the busy-until-the-last-poll case next to the time-out case. The device end at 1024 lets it hit the accept/refuse edge of the size check at both sides.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL_OP,
    ST_POLL_RD,
    ST_WREN,
    ST_HDR,
    ST_DGET,
    ST_DPUT
  } prog_state_t;

  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] FILLER    = 8'h00;
  localparam int         BUSY_BIT  = 0;

endpackage

// File: rtl/prog_chunk_calc.sv
module prog_chunk_calc #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 256,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int CNT_W     = PAGE_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remain,
  output logic [CNT_W-1:0]  chunk
);
  logic [CNT_W-1:0] room;

  always_comb begin
    room = CNT_W'(PAGE_BYTES) - {1'b0, addr[PAGE_W-1:0]};
    if (remain < LEN_W'(room)) chunk = CNT_W'(remain);
    else                       chunk = room;
  end
endmodule

// File: rtl/prog_poll_timer.sv
module prog_poll_timer #(
  parameter int LIMIT = 100000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last_try
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end

  assign last_try = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_prog_splitter.sv
module flash_prog_splitter
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 24,
  parameter int PAGE_BYTES = 256,
  parameter int DEV_BYTES  = 16777216,
  parameter int POLL_LIMIT = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  output logic              xfer_last,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  written
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = PAGE_W + 1;
  localparam int SUM_W  = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  prog_state_t       state;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [CNT_W-1:0]  chunk_left;
  logic [CNT_W-1:0]  chunk_len;
  logic [1:0]        hdr_idx;
  logic [23:0]       addr24;
  logic [SUM_W-1:0]  end_addr;
  logic              over;
  logic              poll_clr, poll_step, poll_last;

  prog_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_calc (
    .addr(cur_addr), .remain(remain), .chunk(chunk_len)
  );

  prog_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .clear(poll_clr), .step(poll_step),
    .last_try(poll_last)
  );

  always_comb begin
    addr24    = 24'(cur_addr);
    end_addr  = SUM_W'(start_addr) + SUM_W'(start_len);
    over      = end_addr > SUM_W'(DEV_BYTES);
    poll_clr  = (state == ST_IDLE) || (state == ST_WREN);
    poll_step = (state == ST_POLL_RD) && xfer_ack && xfer_rx[BUSY_BIT];
    in_ready  = (state == ST_DGET);
    busy      = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      xfer_req   <= 1'b0;
      xfer_tx    <= '0;
      xfer_last  <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      written    <= '0;
      cur_addr   <= '0;
      remain     <= '0;
      chunk_left <= '0;
      hdr_idx    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            written  <= '0;
            cur_addr <= start_addr;
            remain   <= start_len;
            if (start_len == '0) begin
              done <= 1'b1;
              err  <= 1'b0;
            end else if (over) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              err       <= 1'b0;
              xfer_req  <= 1'b1;
              xfer_tx   <= OP_STATUS;
              xfer_last <= 1'b0;
              state     <= ST_POLL_OP;
            end
          end
        end
        ST_POLL_OP: begin
          if (xfer_ack) begin
            xfer_tx   <= FILLER;
            xfer_last <= 1'b1;
            state     <= ST_POLL_RD;
          end
        end
        ST_POLL_RD: begin
          if (xfer_ack) begin
            if (!xfer_rx[BUSY_BIT]) begin
              xfer_tx   <= OP_WREN;
              xfer_last <= 1'b1;
              state     <= ST_WREN;
            end else if (poll_last) begin
              xfer_req  <= 1'b0;
              xfer_last <= 1'b0;
              done      <= 1'b1;
              err       <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              xfer_tx   <= OP_STATUS;
              xfer_last <= 1'b0;
              state     <= ST_POLL_OP;
            end
          end
        end
        ST_WREN: begin
          if (xfer_ack) begin
            chunk_left <= chunk_len;
            xfer_tx    <= OP_PROG;
            xfer_last  <= 1'b0;
            hdr_idx    <= '0;
            state      <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (xfer_ack) begin
            hdr_idx <= hdr_idx + 1'b1;
            unique case (hdr_idx)
              2'd0: xfer_tx <= addr24[23:16];
              2'd1: xfer_tx <= addr24[15:8];
              2'd2: xfer_tx <= addr24[7:0];
              default: begin
                xfer_req <= 1'b0;
                state    <= ST_DGET;
              end
            endcase
          end
        end
        ST_DGET: begin
          if (in_valid) begin
            xfer_req  <= 1'b1;
            xfer_tx   <= in_data;
            xfer_last <= (chunk_left == CNT_W'(1));
            state     <= ST_DPUT;
          end
        end
        ST_DPUT: begin
          if (xfer_ack) begin
            written    <= written + 1'b1;
            cur_addr   <= cur_addr + 1'b1;
            remain     <= remain - 1'b1;
            chunk_left <= chunk_left - 1'b1;
            if (remain == LEN_W'(1)) begin
              xfer_req  <= 1'b0;
              xfer_last <= 1'b0;
              done      <= 1'b1;
              state     <= ST_IDLE;
            end else if (chunk_left == CNT_W'(1)) begin
              xfer_tx   <= OP_STATUS;
              xfer_last <= 1'b0;
              state     <= ST_POLL_OP;
            end else begin
              xfer_req  <= 1'b0;
              xfer_last <= 1'b0;
              state     <= ST_DGET;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_checker.sv
module flash_prog_checker #(
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             xfer_req,
  input logic [7:0]       xfer_tx,
  input logic             xfer_last,
  input logic             xfer_ack,
  input logic             busy,
  input logic             done,
  input logic [LEN_W-1:0] written
);
  p_ready_excl_r7: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !xfer_req);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx) && $stable(xfer_last)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !xfer_req);

  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((written == $past(written)) || (written == $past(written) + 1'b1)));

  p_count_on_ack_r6: assert property (@(posedge clk) disable iff (rst)
    !xfer_ack |=> $stable(written) || !$past(busy));
endmodule

bind flash_prog_splitter flash_prog_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .xfer_req(xfer_req),
  .xfer_tx(xfer_tx), .xfer_last(xfer_last), .xfer_ack(xfer_ack),
  .busy(busy), .done(done), .written(written)
);

// File: tb/tb_flash_prog_splitter.sv
`timescale 1ns/1ps
module tb_flash_prog_splitter;
  localparam int AW = 12;
  localparam int LW = 12;
  localparam int PG = 16;
  localparam int DEV = 1024;
  localparam int LIM = 4;

  // vector: addr(12) len(12) busy_first(8) busy_later(8) ack_delay(8)
  localparam int NV = 7;
  localparam logic [47:0] VEC [NV] = '{
    {12'h000, 12'd16, 8'd0, 8'd0, 8'd0},
    {12'h005, 12'd8,  8'd1, 8'd0, 8'd1},
    {12'h00A, 12'd6,  8'd0, 8'd0, 8'd2},
    {12'h00A, 12'd7,  8'd2, 8'd1, 8'd0},
    {12'h03C, 12'd40, 8'd0, 8'd2, 8'd1},
    {12'h3F0, 12'd16, 8'd1, 8'd0, 8'd0},
    {12'h100, 12'd1,  8'd3, 8'd0, 8'd2}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, in_valid, in_ready, xfer_req, xfer_last, xfer_ack;
  logic busy, done, err;
  logic [AW-1:0] start_addr;
  logic [LW-1:0] start_len, written;
  logic [7:0] in_data, xfer_tx, xfer_rx;

  flash_prog_splitter #(.ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(PG),
                        .DEV_BYTES(DEV), .POLL_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_len(start_len), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_last(xfer_last), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
    .busy(busy), .done(done), .err(err), .written(written)
  );

  int n_chk = 0, n_bad = 0;
  logic [8:0] log_q [0:1023];
  logic [8:0] exp_q [0:1023];
  int log_n = 0, exp_n = 0;
  int busy_left = 0, busy_reload = 0, xdelay = 0;
  bit first_byte = 1'b1, prev_first = 1'b0;
  logic [7:0] prev_byte = 8'h00;
  int host_idx = 0;
  bit take_pend = 1'b0;
  int overlap_bad = 0;
  int exp_cnt;
  bit exp_err;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // byte-exchange shifter model
  initial begin
    int dly;
    dly = 0;
    xfer_ack = 1'b0;
    xfer_rx  = 8'h00;
    forever begin
      @(negedge clk);
      if (in_ready && xfer_req) overlap_bad++;
      if (rst) begin
        xfer_ack = 1'b0;
      end else if (xfer_ack) begin
        xfer_ack = 1'b0;
        dly = xdelay;
      end else if (xfer_req) begin
        if (dly > 0) dly--;
        else begin
          xfer_ack = 1'b1;
          if (prev_first && prev_byte == 8'h05) begin
            if (busy_left > 0) begin xfer_rx = 8'h01; busy_left--; end
            else xfer_rx = 8'hFE;
          end else xfer_rx = 8'h00;
          if (first_byte && xfer_tx == 8'h02) busy_left = busy_reload;
          if (log_n < 1024) log_q[log_n] = {xfer_last, xfer_tx};
          log_n++;
          prev_first = first_byte;
          prev_byte  = xfer_tx;
          first_byte = xfer_last;
        end
      end
    end
  end

  // host byte stream
  initial begin
    in_valid = 1'b1;
    in_data  = 8'h03;
    forever begin
      @(negedge clk);
      if (take_pend) host_idx++;
      in_data   = 8'(host_idx * 7 + 3);
      take_pend = in_valid && in_ready;
    end
  end

  task automatic push(logic last, logic [7:0] b);
    exp_q[exp_n] = {last, b};
    exp_n++;
  endtask

  task automatic build(int addr, int len, int b0, int br, int base);
    int rem, a, sent, bz, n, p;
    exp_n = 0; exp_cnt = 0; exp_err = 1'b0;
    if (len == 0) return;
    if (addr + len > DEV) begin exp_err = 1'b1; return; end
    rem = len; a = addr; sent = 0; bz = b0;
    while (rem > 0) begin
      p = 0;
      while (1) begin
        push(1'b0, 8'h05); push(1'b1, 8'h00);
        p++;
        if (bz > 0) begin
          bz--;
          if (p == LIM) begin exp_err = 1'b1; exp_cnt = sent; return; end
        end else break;
      end
      push(1'b1, 8'h06);
      push(1'b0, 8'h02);
      push(1'b0, 8'((a >> 16) & 255));
      push(1'b0, 8'((a >> 8) & 255));
      push(1'b0, 8'(a & 255));
      bz = br;
      n = PG - (a % PG);
      if (rem < n) n = rem;
      for (int i = 0; i < n; i++)
        push(i == n - 1, 8'((base + sent + i) * 7 + 3));
      sent += n; a += n; rem -= n;
    end
    exp_cnt = sent;
  endtask

  task automatic run(int addr, int len, int b0, int br, int dl, bit inject, string req);
    int base, cyc, mism;
    @(negedge clk);
    log_n = 0; busy_left = b0; busy_reload = br; xdelay = dl;
    first_byte = 1'b1; prev_first = 1'b0;
    base = host_idx;
    build(addr, len, b0, br, base);
    start = 1'b1; start_addr = AW'(addr); start_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      if (inject && cyc == 10) begin
        start = 1'b1; start_addr = '0; start_len = LW'(3);
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done == 1'b1, req, "done seen", int'(done), 1);
    if (len == 0 || exp_n == 0)
      check(cyc == 1, req, "cycles to done", cyc, 1);
    check(err == exp_err, req, "err", int'(err), int'(exp_err));
    check(int'(written) == exp_cnt, req, "written count", int'(written), exp_cnt);
    mism = (log_n != exp_n) ? 1 : 0;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (log_q[i] !== exp_q[i]) mism++;
    check(mism == 0, req, "byte stream (length)", log_n, exp_n);
    repeat (3) @(negedge clk);
    check(log_n == exp_n, req, "no traffic after done", log_n, exp_n);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; start_addr = '0; start_len = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check({busy, done, err, xfer_req, in_ready} == 5'b0, "R9", "control outputs", 
          int'({busy, done, err, xfer_req, in_ready}), 0);
    check(written == '0, "R9", "written", int'(written), 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 R4 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      logic [47:0] e;
      e = VEC[v];
      run(int'(e[47:36]), int'(e[35:24]), int'(e[23:16]), int'(e[15:8]),
          int'(e[7:0]), 1'b0, "R3/R4/R5/R6");
    end

    // R1 zero length
    run(12'h020, 0, 0, 0, 0, 1'b0, "R1");
    // R2 past device end by one
    run(12'h3F0, 17, 0, 0, 0, 1'b0, "R2");
    // R8 time-out on second chunk, partial count kept
    run(12'h00E, 10, 0, 1000, 1, 1'b0, "R8");
    // R8 time-out on the first chunk
    run(12'h040, 5, 1000, 0, 0, 1'b0, "R8");
    // R10 start during a running job
    run(12'h03C, 40, 1, 0, 1, 1'b1, "R10");
    // R7 exclusivity of in_ready and exchange request
    check(overlap_bad == 0, "R7", "in_ready with xfer_req cycles", overlap_bad, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule